// File: doc/BRIEF.md
# Shared Dual-Stack Register File

This block keeps two last-in first-out stacks in one pool of word registers. An operand stack fills the pool from index 0 upward. A return-address stack fills it from the highest index downward. Each stack has its own top-index pointer, one `$clog2(DEPTH)` bits wide, and an empty flag. The two stacks share the free space between them, so either one can grow as long as the pool is not full.

A processor core drives one operation code per clock. The top two operand entries and the top return entry are always visible as combinational reads. The supported operations are:

- operand push
- operand drop
- exchange of the two top operands
- return push
- return pop

An operation that would overrun the shared space, or underrun a stack, is refused. A refused operation changes nothing in storage or in the pointers. It produces a one-cycle refusal pulse, and it moves a small fault state machine from CLEAN to LATCHED. The machine has two states, CLEAN and LATCHED. It has one transition, CLEAN to LATCHED on any refused operation. LATCHED holds until reset.

Top module: `twin_stack_file`

## Requirements
- R1: After reset both depths are 0, `err` and `rej` are 0, and `tos`, `nos` and `rtos` read 0.
- R2: `op`=1 (operand push) with free space puts `wdata` on `tos` after the sampling edge and raises `d_depth` by one. The former `tos` then appears on `nos`.
- R3: `op`=2 (operand drop) on a non-empty operand stack lowers `d_depth` by one. The former `nos` becomes `tos`.
- R4: `op`=3 (exchange) with at least two operands swaps `tos` and `nos` and leaves both depths unchanged.
- R5: `op`=4 (return push) with free space raises `r_depth` by one. `rtos` then shows the low `RADDR_W` bits of `wdata`, zero-extended to the full width.
- R6: `op`=5 (return pop) on a non-empty return stack lowers `r_depth` by one. The entry below then shows on `rtos`.
- R7: Pushes to either stack are accepted while `d_depth + r_depth < DEPTH`. A push when the sum equals `DEPTH` is refused.
- R8: The following are refused: a drop with `d_depth`=0, an exchange with `d_depth`<2, and a return pop with `r_depth`=0.
- R9: A refused operation leaves the depths and all three read ports unchanged. It raises `rej` for the one cycle after its sampling edge. It sets `err`, which stays 1 until reset.
- R10: `op` values 0, 6 and 7 change nothing and are never refused.
- R11: `tos` reads 0 when `d_depth`=0. `nos` reads 0 when `d_depth`<2. `rtos` reads 0 when `r_depth`=0.
- R12: Operand operations never change `rtos` or `r_depth`. Return operations never change `tos`, `nos` or `d_depth`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Operation code: 0 none, 1 operand push, 2 drop, 3 exchange, 4 return push, 5 return pop, 6/7 none |
| wdata | input | WIDTH | Value for a push |
| tos | output | WIDTH | Top operand entry |
| nos | output | WIDTH | Second operand entry |
| rtos | output | WIDTH | Top return entry |
| d_depth | output | $clog2(DEPTH)+1 | Operand stack depth |
| r_depth | output | $clog2(DEPTH)+1 | Return stack depth |
| err | output | 1 | Sticky fault (LATCHED state) |
| rej | output | 1 | One-cycle pulse after a refused operation |

## Verification
The properties check the following on every cycle:

- The combined depth never exceeds the pool size.
- `err` never falls outside reset.
- A legal push, exchange or return push lands its value on the right read port.
- An underflow pop is refused without any change in depth.
- Empty stacks read as zero.

Other behaviours can only be shown by the bench's scenarios. The bench fills the pool to every possible split between the two stacks and walks it back down. This shows that entries come back in LIFO order through long push/pop runs. It shows that the collision point is exact for every split. It shows that operations on one stack leave the other one's contents intact.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_DPUSH = 3'd1,
        OP_DDROP = 3'd2,
        OP_XCHG  = 3'd3,
        OP_RPUSH = 3'd4,
        OP_RPOP  = 3'd5,
        OP_SPARE6 = 3'd6,
        OP_SPARE7 = 3'd7
    } stk_op_e;

    typedef enum logic {
        FLT_CLEAN   = 1'b0,
        FLT_LATCHED = 1'b1
    } flt_state_e;

endpackage

// File: rtl/tsf_ptr_unit.sv
module tsf_ptr_unit
    import tsf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    output logic [PTR_W-1:0] dp,
    output logic [PTR_W-1:0] rp,
    output logic [CNT_W-1:0] d_cnt,
    output logic [CNT_W-1:0] r_cnt,
    output logic             legal
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W:0]   FULL_C  = (CNT_W+1)'(DEPTH);
    localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);

    logic           d_empty;
    logic           r_empty;
    logic [CNT_W:0] occ;
    logic           room;

    // Occupancy derived from pointer plus empty flag
    assign d_cnt = d_empty ? '0 : ({1'b0, dp} + CNT_W'(1));
    assign r_cnt = r_empty ? '0 : (DEPTH_C - {1'b0, rp});
    assign occ   = {1'b0, d_cnt} + {1'b0, r_cnt};
    assign room  = (occ < FULL_C);

    always_comb begin
        unique case (op)
            OP_DPUSH: legal = room;
            OP_DDROP: legal = (d_cnt != '0);
            OP_XCHG:  legal = (d_cnt >= CNT_W'(2));
            OP_RPUSH: legal = room;
            OP_RPOP:  legal = (r_cnt != '0);
            default:  legal = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp      <= '0;
            d_empty <= 1'b1;
            rp      <= TOP_IDX;
            r_empty <= 1'b1;
        end else if (legal) begin
            unique case (op)
                OP_DPUSH: begin
                    if (d_empty) begin
                        d_empty <= 1'b0;
                        dp      <= '0;
                    end else begin
                        dp <= dp + PTR_W'(1);
                    end
                end
                OP_DDROP: begin
                    if (dp == '0) d_empty <= 1'b1;
                    else          dp      <= dp - PTR_W'(1);
                end
                OP_RPUSH: begin
                    if (r_empty) begin
                        r_empty <= 1'b0;
                        rp      <= TOP_IDX;
                    end else begin
                        rp <= rp - PTR_W'(1);
                    end
                end
                OP_RPOP: begin
                    if (rp == TOP_IDX) r_empty <= 1'b1;
                    else               rp      <= rp + PTR_W'(1);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tsf_store.sv
module tsf_store
    import tsf_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int DEPTH   = 16,
    parameter int RADDR_W = 10,
    parameter int PTR_W   = $clog2(DEPTH),
    parameter int CNT_W   = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    input  logic             legal,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] dp,
    input  logic [PTR_W-1:0] rp,
    input  logic [CNT_W-1:0] d_cnt,
    input  logic [CNT_W-1:0] r_cnt,
    output logic [WIDTH-1:0] tos,
    output logic [WIDTH-1:0] nos,
    output logic [WIDTH-1:0] rtos
);

    localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] cells [DEPTH];
    logic [PTR_W-1:0] nos_idx;
    logic [PTR_W-1:0] dpush_idx;
    logic [PTR_W-1:0] rpush_idx;

    logic             a_en, b_en;
    logic [PTR_W-1:0] a_idx, b_idx;
    logic [WIDTH-1:0] a_dat, b_dat;

    assign nos_idx   = dp - PTR_W'(1);
    assign dpush_idx = d_cnt[PTR_W-1:0];
    assign rpush_idx = TOP_IDX - r_cnt[PTR_W-1:0];

    // Two write ports: the exchange writes both top cells in one edge
    always_comb begin
        a_en  = 1'b0;
        b_en  = 1'b0;
        a_idx = '0;
        b_idx = '0;
        a_dat = '0;
        b_dat = '0;
        if (legal) begin
            unique case (op)
                OP_DPUSH: begin
                    a_en  = 1'b1;
                    a_idx = dpush_idx;
                    a_dat = wdata;
                end
                OP_XCHG: begin
                    a_en  = 1'b1;
                    a_idx = dp;
                    a_dat = cells[nos_idx];
                    b_en  = 1'b1;
                    b_idx = nos_idx;
                    b_dat = cells[dp];
                end
                OP_RPUSH: begin
                    a_en  = 1'b1;
                    a_idx = rpush_idx;
                    a_dat = WIDTH'(wdata[RADDR_W-1:0]);
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[g] <= '0;
            else if (a_en && (a_idx == PTR_W'(g)))
                cells[g] <= a_dat;
            else if (b_en && (b_idx == PTR_W'(g)))
                cells[g] <= b_dat;
        end
    end

    assign tos  = (d_cnt != '0)          ? cells[dp]      : '0;
    assign nos  = (d_cnt >= CNT_W'(2))   ? cells[nos_idx] : '0;
    assign rtos = (r_cnt != '0)          ? cells[rp]      : '0;

endmodule

// File: rtl/tsf_fault_fsm.sv
module tsf_fault_fsm
    import tsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic refused,
    output logic err,
    output logic rej
);

    flt_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            FLT_CLEAN:   if (refused) state_nxt = FLT_LATCHED;
            FLT_LATCHED: state_nxt = FLT_LATCHED;
            default:     state_nxt = FLT_LATCHED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLT_CLEAN;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rej <= 1'b0;
        else        rej <= refused;
    end

    assign err = (state == FLT_LATCHED);

endmodule

// File: rtl/twin_stack_file.sv
module twin_stack_file
    import tsf_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int DEPTH   = 16,
    parameter int RADDR_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               op,
    input  logic [WIDTH-1:0]         wdata,
    output logic [WIDTH-1:0]         tos,
    output logic [WIDTH-1:0]         nos,
    output logic [WIDTH-1:0]         rtos,
    output logic [$clog2(DEPTH):0]   d_depth,
    output logic [$clog2(DEPTH):0]   r_depth,
    output logic                     err,
    output logic                     rej
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    stk_op_e          op_e;
    logic [PTR_W-1:0] dp, rp;
    logic [CNT_W-1:0] d_cnt, r_cnt;
    logic             legal;

    assign op_e = stk_op_e'(op);

    tsf_ptr_unit #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op_e),
        .dp    (dp),
        .rp    (rp),
        .d_cnt (d_cnt),
        .r_cnt (r_cnt),
        .legal (legal)
    );

    tsf_store #(
        .WIDTH   (WIDTH),
        .DEPTH   (DEPTH),
        .RADDR_W (RADDR_W),
        .PTR_W   (PTR_W),
        .CNT_W   (CNT_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op_e),
        .legal (legal),
        .wdata (wdata),
        .dp    (dp),
        .rp    (rp),
        .d_cnt (d_cnt),
        .r_cnt (r_cnt),
        .tos   (tos),
        .nos   (nos),
        .rtos  (rtos)
    );

    tsf_fault_fsm u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .refused (!legal),
        .err     (err),
        .rej     (rej)
    );

    assign d_depth = d_cnt;
    assign r_depth = r_cnt;

endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
    parameter int WIDTH   = 16,
    parameter int DEPTH   = 16,
    parameter int RADDR_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [2:0]             op,
    input logic [WIDTH-1:0]       wdata,
    input logic [WIDTH-1:0]       tos,
    input logic [WIDTH-1:0]       nos,
    input logic [WIDTH-1:0]       rtos,
    input logic [$clog2(DEPTH):0] d_depth,
    input logic [$clog2(DEPTH):0] r_depth,
    input logic                   err,
    input logic                   rej
);

    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam logic [CNT_W:0] FULL_C = (CNT_W+1)'(DEPTH);

    logic [CNT_W:0] occ;
    logic           room;

    assign occ  = {1'b0, d_depth} + {1'b0, r_depth};
    assign room = (occ < FULL_C);

    assert_capacity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_C);

    assert_sticky_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_drop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2 && d_depth == '0) |=> (rej && err && $stable(d_depth) && $stable(r_depth)));

    assert_rpop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5 && r_depth == '0) |=> (rej && $stable(r_depth) && $stable(tos)));

    assert_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1 && room) |=> (tos == $past(wdata) && d_depth == $past(d_depth) + CNT_W'(1)));

    assert_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && d_depth >= CNT_W'(2)) |=> (tos == $past(nos) && nos == $past(tos) && $stable(d_depth)));

    assert_rpush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd4 && room) |=> (rtos == WIDTH'($past(wdata[RADDR_W-1:0]))));

    assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (d_depth == '0) |-> (tos == '0 && nos == '0));

    assert_empty_ret_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_depth == '0) |-> (rtos == '0));

endmodule

bind twin_stack_file tsf_checker #(
    .WIDTH   (WIDTH),
    .DEPTH   (DEPTH),
    .RADDR_W (RADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .wdata   (wdata),
    .tos     (tos),
    .nos     (nos),
    .rtos    (rtos),
    .d_depth (d_depth),
    .r_depth (r_depth),
    .err     (err),
    .rej     (rej)
);

// File: tb/sim_twin_stack_file.sv
`timescale 1ns/1ps
module sim_twin_stack_file;

    localparam int W  = 16;
    localparam int D  = 16;
    localparam int RW = 10;
    localparam int CW = $clog2(D) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  tos, nos, rtos;
    logic [CW-1:0] d_depth, r_depth;
    logic          err, rej;

    int n_tests = 0;
    int n_fail  = 0;

    logic [W-1:0] md [D];
    logic [W-1:0] mr [D];
    int           mdc, mrc;
    bit           merr;

    always #10 clk = ~clk;

    twin_stack_file #(.WIDTH(W), .DEPTH(D), .RADDR_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata(wdata),
        .tos(tos), .nos(nos), .rtos(rtos),
        .d_depth(d_depth), .r_depth(r_depth), .err(err), .rej(rej)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string dtag, input string rtag, input bit exp_rej);
        logic [W-1:0] e_tos, e_nos, e_rtos;
        e_tos  = (mdc > 0) ? md[mdc-1] : '0;
        e_nos  = (mdc > 1) ? md[mdc-2] : '0;
        e_rtos = (mrc > 0) ? mr[mrc-1] : '0;
        chk((mdc == 0) ? "R11" : dtag, "tos", 32'(tos), 32'(e_tos));
        chk((mdc < 2) ? "R11" : dtag, "nos", 32'(nos), 32'(e_nos));
        chk(dtag, "d_depth", 32'(d_depth), 32'(mdc));
        chk((mrc == 0) ? "R11" : rtag, "rtos", 32'(rtos), 32'(e_rtos));
        chk(rtag, "r_depth", 32'(r_depth), 32'(mrc));
        chk("R9", "err", 32'(err), 32'(merr));
        chk(exp_rej ? "R9" : dtag, "rej", 32'(rej), 32'(exp_rej));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op    = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mdc = 0; mrc = 0; merr = 1'b0;
        for (int i = 0; i < D; i++) begin
            md[i] = '0;
            mr[i] = '0;
        end
        #2;
        check_all("R1", "R1", 1'b0);
    endtask

    task automatic do_op(input logic [2:0] o, input logic [W-1:0] v);
        bit    legal;
        bit    room;
        string tag;
        logic [W-1:0] t;
        @(negedge clk);
        op    = o;
        wdata = v;
        @(posedge clk);
        #2;
        op = 3'd0;
        room = (mdc + mrc) < D;
        tag  = "R10";
        case (o)
            3'd1: begin
                legal = room; tag = legal ? "R2" : "R7";
                if (legal) begin md[mdc] = v; mdc++; end
            end
            3'd2: begin
                legal = (mdc > 0); tag = legal ? "R3" : "R8";
                if (legal) mdc--;
            end
            3'd3: begin
                legal = (mdc > 1); tag = legal ? "R4" : "R8";
                if (legal) begin
                    t = md[mdc-1]; md[mdc-1] = md[mdc-2]; md[mdc-2] = t;
                end
            end
            3'd4: begin
                legal = room; tag = legal ? "R5" : "R7";
                if (legal) begin mr[mrc] = W'(v[RW-1:0]); mrc++; end
            end
            3'd5: begin
                legal = (mrc > 0); tag = legal ? "R6" : "R8";
                if (legal) mrc--;
            end
            default: legal = 1'b1;
        endcase
        if (!legal) merr = 1'b1;
        if (o == 3'd4 || o == 3'd5)
            check_all("R12", tag, !legal);
        else if (o >= 3'd1 && o <= 3'd3)
            check_all(tag, "R12", !legal);
        else
            check_all(tag, tag, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run incomplete, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        do_reset();

        // Every split of the pool between the two stacks
        for (int k = 0; k <= D; k++) begin
            do_reset();
            for (int i = 0; i < k; i++) do_op(3'd1, W'(16'h1000 + k * 97 + i * 13));
            do_op(3'd3, '0);
            do_op(3'd3, '0);
            for (int i = k; i < D; i++) do_op(3'd4, W'(16'hFC00 | (k * 31 + i * 7)));
            do_op(3'd4, 16'h0155);
            do_op(3'd1, 16'hBEEF);
            do_op(3'd6, 16'h1234);
            do_op(3'd7, 16'h4321);
            for (int i = k; i < D; i++) do_op(3'd5, '0);
            do_op(3'd5, '0);
            for (int i = 0; i < k; i++) do_op(3'd2, '0);
            do_op(3'd2, '0);
            do_op(3'd3, '0);
        end

        // Interleaved mix before any fault, then a long mixed run
        do_reset();
        for (int i = 0; i < 6; i++) begin
            do_op(3'd1, W'(16'h2200 + i));
            do_op(3'd4, W'(16'hA300 + i));
        end
        do_op(3'd3, '0);
        do_op(3'd5, '0);
        do_op(3'd2, '0);
        do_op(3'd0, 16'hFFFF);

        do_reset();
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_op(lf[2:0], W'(lf * 16'd3 + 16'(i)));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule